// File: doc/BRIEF.md
# SPI OTP Register Read Engine

This block is the serial slave front end that answers a single read command on a 128-byte one-time-programmable register array. A host pulls chip select low and shifts in an opcode, a 24-bit start address and two don't-care bytes. The engine then streams register bytes back, most significant bit first, and keeps going for as long as the host supplies clocks. After the last location it wraps to the first one with no gap. Raising chip select at any bit position ends the read and releases the data-out pin.

The serial pins are oversampled in the system clock domain, so SCK must run well below the system clock: the bench keeps at least 16 system clocks per SCK period. Bytes come from an external synchronous array through a request/response port. A request is offered with `arr_req_valid` and `arr_req_addr`. Once valid is raised, it stays high with the address unchanged until a cycle in which `arr_req_ready` is high; that cycle is the acceptance. The array answers with `arr_rsp_valid` and `arr_rsp_data` exactly one cycle after acceptance. The engine always takes a response, so the response channel has no back-pressure. The array must accept a request within a few SCK bit times, because the engine fetches one byte ahead of the byte it is shifting out. A request outstanding when chip select rises is still held until it is accepted, and its response is discarded.

Top module: `otp_spi_reader`

## Requirements
- R1: A read begins only when the first 8 bits sampled after chip select falls, taken MSB first, equal 77h.
- R2: The next 24 bits are the start address, MSB first; only its 7 least significant bits select the array byte, and the upper 17 bits are ignored.
- R3: During the 16 bits after the address, and during the opcode and address bits, data out stays disabled; bit 7 of the first byte is driven after the first falling SCK edge that follows the 48th rising edge.
- R4: Each byte goes out MSB first, and successive bytes come from successive array addresses.
- R5: After array address 7Fh, output continues at 00h with no extra SCK cycles.
- R6: When chip select rises, at any bit position, data out is disabled within 4 system clocks; a partly sent byte is simply abandoned.
- R7: SCK may idle low (mode 0) or high (mode 3); both idle levels give identical data.
- R8: Any opcode other than 77h keeps data out disabled until chip select rises.
- R9: A transaction that ends inside the address or dummy bits, or just after a byte load, produces no output and does not affect the next transaction.
- R10: An array request keeps valid high and its address stable until accepted; after reset no request is pending.
- R11: Input bits are sampled on rising SCK; data out changes only after falling SCK, so it is stable while SCK is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, meaningful when enabled |
| spi_miso_oe | output | 1 | Output enable; low means high impedance |
| arr_req_valid | output | 1 | Array read request valid |
| arr_req_ready | input | 1 | Array accepts the request |
| arr_req_addr | output | 7 | Array byte address |
| arr_rsp_valid | input | 1 | Read data valid, one cycle after acceptance |
| arr_rsp_data | input | 8 | Read data byte |

## Verification
Two things can coincide: the host deselects while a prefetch for the next byte is still outstanding at the array port. The bench provokes this by ending a read one bit past the first byte load while it holds the array's ready low. The stalled request then completes only after chip select has risen. The check is that the next read, at a different address, returns its own bytes and not the stale one, and that the request stayed valid with a steady address throughout the stall.

// File: rtl/otp_rd_pkg.sv
package otp_rd_pkg;
  // Phases of one chip-select window
  typedef enum logic [2:0] {
    PH_OPC   = 3'd0,
    PH_ADDR  = 3'd1,
    PH_DUMMY = 3'd2,
    PH_DATA  = 3'd3,
    PH_SKIP  = 3'd4
  } rd_phase_e;
endpackage

// File: rtl/otp_pin_sync.sv
module otp_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_act,
  output logic mosi_s
);
  localparam int LAST = STAGES - 1;

  // each stage carries {sck, cs_n, mosi}
  logic [2:0] chain [STAGES];
  logic       sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= 3'b010;
      sck_prev <= 1'b0;
    end else begin
      chain[0] <= {sck_i, cs_n_i, mosi_i};
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      sck_prev <= chain[LAST][2];
    end
  end

  assign cs_act   = ~chain[LAST][1];
  assign mosi_s   = chain[LAST][0];
  assign sck_rise = cs_act & chain[LAST][2] & ~sck_prev;
  assign sck_fall = cs_act & ~chain[LAST][2] & sck_prev;
endmodule

// File: rtl/otp_cmd_decode.sv
module otp_cmd_decode
  import otp_rd_pkg::*;
#(
  parameter int              ADDR_W        = 7,
  parameter int              OPC_W         = 8,
  parameter logic [OPC_W-1:0] OPCODE       = 8'h77,
  parameter int              CMD_ADDR_BITS = 24,
  parameter int              DUMMY_BITS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sck_rise,
  input  logic              mosi_s,
  output rd_phase_e         phase,
  output logic [ADDR_W-1:0] start_addr,
  output logic              start_pulse
);
  localparam int PH_MAX = (CMD_ADDR_BITS > DUMMY_BITS)
                        ? ((CMD_ADDR_BITS > OPC_W) ? CMD_ADDR_BITS : OPC_W)
                        : ((DUMMY_BITS > OPC_W) ? DUMMY_BITS : OPC_W);
  localparam int CNT_W = $clog2(PH_MAX + 1);
  localparam logic [CNT_W-1:0] OPC_LAST   = CNT_W'(OPC_W - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST  = CNT_W'(CMD_ADDR_BITS - 1);
  localparam logic [CNT_W-1:0] DUMMY_LAST = CNT_W'(DUMMY_BITS - 1);

  logic [CNT_W-1:0] cnt;
  logic [OPC_W-1:0] opc_sh;
  logic [OPC_W-1:0] opc_next;

  assign opc_next = {opc_sh[OPC_W-2:0], mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_OPC;
      cnt         <= '0;
      opc_sh      <= '0;
      start_addr  <= '0;
      start_pulse <= 1'b0;
    end else begin
      start_pulse <= 1'b0;
      if (!cs_act) begin
        // deselect wipes every partial field
        phase      <= PH_OPC;
        cnt        <= '0;
        opc_sh     <= '0;
        start_addr <= '0;
      end else if (sck_rise) begin
        unique case (phase)
          PH_OPC: begin
            opc_sh <= opc_next;
            if (cnt == OPC_LAST) begin
              cnt   <= '0;
              phase <= (opc_next == OPCODE) ? PH_ADDR : PH_SKIP;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          PH_ADDR: begin
            // only the low bits survive the shift
            start_addr <= {start_addr[ADDR_W-2:0], mosi_s};
            if (cnt == ADDR_LAST) begin
              cnt         <= '0;
              phase       <= PH_DUMMY;
              start_pulse <= 1'b1;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          PH_DUMMY: begin
            if (cnt == DUMMY_LAST) begin
              cnt   <= '0;
              phase <= PH_DATA;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/otp_prefetch.sv
module otp_prefetch #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              start_pulse,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              advance,
  output logic [DATA_W-1:0] buf_data,
  output logic              buf_valid,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data
);
  logic [ADDR_W-1:0] next_addr;
  logic              req_stale;
  logic              rsp_stale;
  logic              req_fire;

  assign req_fire = req_valid & req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_addr  <= '0;
      next_addr <= '0;
      req_stale <= 1'b0;
      rsp_stale <= 1'b0;
      buf_data  <= '0;
      buf_valid <= 1'b0;
    end else begin
      // response lands one cycle after acceptance: capture its fate now
      rsp_stale <= req_stale | ~cs_act;

      if (req_fire) begin
        req_valid <= 1'b0;
        req_stale <= 1'b0;
      end else if (req_valid && !cs_act) begin
        req_stale <= 1'b1;
      end

      if (cs_act && start_pulse) begin
        req_valid <= 1'b1;
        req_addr  <= start_addr;
        next_addr <= start_addr + ADDR_W'(1);
      end else if (cs_act && advance) begin
        req_valid <= 1'b1;
        req_addr  <= next_addr;
        next_addr <= next_addr + ADDR_W'(1);
      end

      if (!cs_act) begin
        buf_valid <= 1'b0;
      end else begin
        if (advance) buf_valid <= 1'b0;
        if (rsp_valid && !rsp_stale) begin
          buf_data  <= rsp_data;
          buf_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/otp_tx_shift.sv
module otp_tx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sck_fall,
  input  logic              data_phase,
  input  logic [DATA_W-1:0] buf_data,
  input  logic              buf_valid,
  output logic              so_data,
  output logic              so_en,
  output logic              advance
);
  localparam int BC_W = $clog2(DATA_W);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(DATA_W - 1);

  logic [BC_W-1:0]   bit_cnt;
  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] load;

  assign load = buf_valid ? buf_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      so_data <= 1'b0;
      so_en   <= 1'b0;
      advance <= 1'b0;
      bit_cnt <= '0;
      sh      <= '0;
    end else begin
      advance <= 1'b0;
      if (!cs_act) begin
        so_data <= 1'b0;
        so_en   <= 1'b0;
        bit_cnt <= '0;
        sh      <= '0;
      end else if (sck_fall && data_phase) begin
        so_en <= 1'b1;
        if (bit_cnt == '0) begin
          so_data <= load[DATA_W-1];
          sh      <= {load[DATA_W-2:0], 1'b0};
          advance <= 1'b1;
        end else begin
          so_data <= sh[DATA_W-1];
          sh      <= {sh[DATA_W-2:0], 1'b0};
        end
        bit_cnt <= (bit_cnt == BC_LAST) ? '0 : bit_cnt + BC_W'(1);
      end
    end
  end
endmodule

// File: rtl/otp_spi_reader.sv
module otp_spi_reader
  import otp_rd_pkg::*;
#(
  parameter int               ADDR_W        = 7,
  parameter int               DATA_W        = 8,
  parameter int               OPC_W         = 8,
  parameter logic [OPC_W-1:0] OPCODE        = 8'h77,
  parameter int               CMD_ADDR_BITS = 24,
  parameter int               DUMMY_BITS    = 16,
  parameter int               SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic              arr_req_valid,
  input  logic              arr_req_ready,
  output logic [ADDR_W-1:0] arr_req_addr,
  input  logic              arr_rsp_valid,
  input  logic [DATA_W-1:0] arr_rsp_data
);
  logic              sck_rise;
  logic              sck_fall;
  logic              cs_act;
  logic              mosi_s;
  rd_phase_e         phase;
  logic [ADDR_W-1:0] start_addr;
  logic              start_pulse;
  logic [DATA_W-1:0] buf_data;
  logic              buf_valid;
  logic              advance;
  logic              data_phase;

  assign data_phase = (phase == PH_DATA);

  otp_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .sck_i(spi_sck), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_act(cs_act), .mosi_s(mosi_s)
  );

  otp_cmd_decode #(
    .ADDR_W(ADDR_W), .OPC_W(OPC_W), .OPCODE(OPCODE),
    .CMD_ADDR_BITS(CMD_ADDR_BITS), .DUMMY_BITS(DUMMY_BITS)
  ) u_dec (
    .clk(clk), .rst_n(rst_n),
    .cs_act(cs_act), .sck_rise(sck_rise), .mosi_s(mosi_s),
    .phase(phase), .start_addr(start_addr), .start_pulse(start_pulse)
  );

  otp_prefetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .cs_act(cs_act), .start_pulse(start_pulse), .start_addr(start_addr),
    .advance(advance),
    .buf_data(buf_data), .buf_valid(buf_valid),
    .req_valid(arr_req_valid), .req_addr(arr_req_addr),
    .req_ready(arr_req_ready),
    .rsp_valid(arr_rsp_valid), .rsp_data(arr_rsp_data)
  );

  otp_tx_shift #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .cs_act(cs_act), .sck_fall(sck_fall), .data_phase(data_phase),
    .buf_data(buf_data), .buf_valid(buf_valid),
    .so_data(spi_miso), .so_en(spi_miso_oe), .advance(advance)
  );
endmodule

// File: rtl/otp_spi_reader_chk.sv
module otp_spi_reader_chk
  import otp_rd_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_act,
  input logic              sck_fall,
  input rd_phase_e         phase,
  input logic              so_data,
  input logic              so_en,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid
);
  // R6: deselect releases the output on the next edge
  a_r6_release_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !so_en);

  // R11: an enabled output only toggles in reaction to a falling SCK
  a_r11_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (so_en && $past(so_en) && (so_data != $past(so_data))) |-> $past(sck_fall));

  // R3: output turns on only once the data phase is reached
  a_r3_enable_in_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_en) |-> (phase == PH_DATA));

  // R9: nothing is driven while address or dummy bits arrive
  a_r9_quiet_header: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_ADDR) || (phase == PH_DUMMY)) |-> !so_en);

  // R8: an unrecognized opcode keeps the pin released
  a_r8_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP) |-> !so_en);

  // R10: a stalled request holds valid and address
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  // R10: responses only follow an accepted request
  a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready));
endmodule

bind otp_spi_reader otp_spi_reader_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_fall(sck_fall),
  .phase(phase), .so_data(spi_miso), .so_en(spi_miso_oe),
  .req_valid(arr_req_valid), .req_ready(arr_req_ready),
  .req_addr(arr_req_addr), .rsp_valid(arr_rsp_valid)
);

// File: tb/otp_spi_reader_tb.sv
`timescale 1ns/1ps
module otp_spi_reader_tb;
  localparam int H = 8;  // system clocks per SCK half period

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sck = 1'b0;
  logic       spi_cs_n = 1'b1;
  logic       spi_mosi = 1'b0;
  logic       spi_miso;
  logic       spi_miso_oe;
  logic       arr_req_valid;
  logic       arr_req_ready;
  logic [6:0] arr_req_addr;
  logic       arr_rsp_valid = 1'b0;
  logic [7:0] arr_rsp_data = 8'h00;
  logic       pad;

  logic [7:0] mem [128];
  logic [7:0] exp_q [$];
  int         n_cmp = 0;
  int         n_bad = 0;
  int         rdy_cnt = 0;
  bit         hold_ready = 1'b0;
  bit         tb_data_bit = 1'b0;
  bit         done = 1'b0;
  string      cur_req = "";
  logic [7:0] mbyte = 8'h00;
  int         mbits = 0;

  always #2 clk = ~clk;  // 250 MHz

  assign pad = spi_miso_oe ? spi_miso : 1'bz;
  assign arr_req_ready = !hold_ready && ((rdy_cnt % 3) != 0);

  otp_spi_reader u_dut (
    .clk(clk), .rst_n(rst_n),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .arr_req_valid(arr_req_valid), .arr_req_ready(arr_req_ready),
    .arr_req_addr(arr_req_addr),
    .arr_rsp_valid(arr_rsp_valid), .arr_rsp_data(arr_rsp_data)
  );

  // array model: answers one cycle after acceptance
  always @(posedge clk) begin
    rdy_cnt       <= rdy_cnt + 1;
    arr_rsp_valid <= arr_req_valid && arr_req_ready;
    arr_rsp_data  <= mem[arr_req_addr];
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: assembles bytes on rising SCK and scores them
  always @(posedge spi_sck or posedge spi_cs_n) begin
    if (spi_cs_n) begin
      mbits = 0;
    end else if (tb_data_bit) begin
      mbyte = {mbyte[6:0], pad};
      mbits++;
      if (mbits == 8) begin
        mbits = 0;
        if (exp_q.size() == 0) begin
          check(1'b0, cur_req, "unexpected byte", int'(mbyte), 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(mbyte === e, cur_req, "data byte", int'(mbyte), int'(e));
        end
      end
    end
  end

  // driver: one chip-select window of nbits, expected bytes go to the queue
  task automatic xfer(bit mode3, logic [7:0] opc, logic [23:0] addr, int nbits,
                      bit stall, string req, string quiet_req);
    logic [47:0] hdr;
    bit          rd;
    int          nfull;
    bit          quiet_ok;
    logic        v;
    hdr      = {opc, addr, 16'hA5C3};
    rd       = (opc == 8'h77);
    nfull    = (rd && nbits >= 48) ? (nbits - 48) / 8 : 0;
    quiet_ok = 1'b1;
    cur_req  = req;
    for (int k = 0; k < nfull; k++) exp_q.push_back(mem[7'(addr[6:0] + 7'(k))]);
    spi_sck = mode3;
    wait_clk(H);
    spi_cs_n = 1'b0;
    wait_clk(H);
    for (int i = 0; i < nbits; i++) begin
      if (stall && i == 48) hold_ready = 1'b1;
      spi_sck     = 1'b0;
      spi_mosi    = (i < 48) ? hdr[47-i] : 1'b1;
      tb_data_bit = rd && (i >= 48) && (i < 48 + nfull * 8);
      wait_clk(H);
      spi_sck = 1'b1;
      if ((i < 48 || !rd) && spi_miso_oe) quiet_ok = 1'b0;
      v = spi_miso;
      wait_clk(H);
      if (tb_data_bit) check(spi_miso == v, "R11", "stable while SCK high", int'(spi_miso), int'(v));
    end
    if (!mode3) begin
      spi_sck = 1'b0;
      wait_clk(H);
    end
    spi_cs_n    = 1'b1;
    tb_data_bit = 1'b0;
    wait_clk(4);
    check(quiet_ok, quiet_req, "output enabled before data", 1, 0);
    check(!spi_miso_oe, "R6", "enable after deselect", int'(spi_miso_oe), 0);
    check(exp_q.size() == 0, req, "bytes not delivered", exp_q.size(), 0);
    wait_clk(H);
    hold_ready = 1'b0;
    wait_clk(H);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 8'((i * 29 + 8'h5A) ^ (i >> 3));
    wait_clk(5);
    check(!spi_miso_oe, "R6", "reset enable", int'(spi_miso_oe), 0);
    check(!arr_req_valid, "R10", "reset request", int'(arr_req_valid), 0);
    rst_n = 1'b1;
    wait_clk(4);
    // R1 R4 R10 R3: plain mode 0 read
    xfer(1'b0, 8'h77, 24'h000010, 48 + 5 * 8, 1'b0, "R1 R4 R10", "R3");
    // R2 R5 R7: mode 3, high address bits ignored, wraps past 7Fh
    xfer(1'b1, 8'h77, 24'hABCD7D, 48 + 6 * 8, 1'b0, "R2 R5 R7", "R3");
    // R5: more than a full lap of the array
    xfer(1'b0, 8'h77, 24'h00007F, 48 + 130 * 8, 1'b0, "R5", "R3");
    // R6: deselect in the middle of a byte
    xfer(1'b1, 8'h77, 24'h000040, 48 + 3 * 8 + 5, 1'b0, "R6", "R3");
    // R8: unknown opcode
    xfer(1'b0, 8'h0B, 24'h000000, 64, 1'b0, "R8", "R8");
    // R9: cut inside address, inside dummy, and right after a load with a stalled prefetch
    xfer(1'b1, 8'h77, 24'h000020, 20, 1'b0, "R9", "R9");
    xfer(1'b0, 8'h77, 24'h000021, 40, 1'b0, "R9", "R9");
    xfer(1'b0, 8'h77, 24'h000003, 49, 1'b1, "R9", "R9");
    xfer(1'b1, 8'h77, 24'h000070, 48 + 4 * 8, 1'b0, "R9 R10", "R9");
    // R2 R5: all-ones address maps to 7Fh then 00h
    xfer(1'b0, 8'h77, 24'hFFFFFF, 48 + 2 * 8, 1'b0, "R2 R5", "R3");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule